// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clocked model of the command interpreter that sits in front of a byte-wide flash array. The host drives single-cycle write and read strobes with an address and a data byte. A write is taken as one step of a command. Commands open with a two-step unlock key and then select a byte program, a sector erase, a chip erase, the identification mode or a return to plain read mode. The block holds the array, applies the program and erase rules to it, and times each internal operation with a cycle counter.

Reads return one of three things. In normal read mode they return array contents. In the identification mode they return fixed ID bytes. While a program or erase is running they return a status byte. The `busy` output covers the whole timed window. Every write that arrives during that window is dropped and does not advance the decoder. The durations are parameters counted in clock cycles, so a short simulation can use small values and a real build can use the worst-case times.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `busy` is low, every array byte reads FFh and the decoder is in read mode. A read accepted on `rd_en` at a clock edge shows its result on `rdata` after that edge, for the following cycle.
- R2: The unlock key is a write of AAh to address 5555h followed by a write of 55h to 2AAAh. Both addresses are compared on address bits 14..0 only, and the bits above are ignored.
- R3: Byte program is the key, then A0h written to 5555h, then the data written to the target. The target byte becomes the bitwise AND of its old value and the new data. The array index is the low `ARRAY_AW` address bits.
- R4: Sector erase is the key, 80h to 5555h, the key again, then 30h to any address. Every byte whose array index bits above bit `OFS_W-1` match that address becomes FFh. All other sectors keep their contents.
- R5: Chip erase is the same six-step form with 10h written to 5555h as the last step. It sets every array byte to FFh.
- R6: Identification mode is the key followed by 90h to 5555h. In this mode a read with address low byte 00h returns 40h, 01h returns 82h, and any other value returns 00h. The first write of any kind leaves the mode.
- R7: A single write of F0h to any address returns the decoder to read mode. So does F0h written to 5555h after the key.
- R8: A write that does not match the next expected step returns the decoder to read mode and changes no array byte. The data write of a program is exempt, since any value there is accepted.
- R9: `busy` rises in the cycle after the final command write. It stays high for exactly max(`PROG_CYCLES`,2) cycles for a program, max(`SECT_CYCLES`, sector size) for a sector erase and max(`CHIP_CYCLES`, array size) for a chip erase.
- R10: Writes while `busy` is high are ignored. They alter no byte and do not advance the command decoder.
- R11: A read while `busy` is high returns status 01h during an erase and 02h during a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe: one command step per asserted cycle |
| rd_en | input | 1 | Read strobe; must not be asserted together with `wr_en` |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read result, valid in the cycle after `rd_en` |
| busy | output | 1 | High while a program or erase is running |

## Verification
The bench programs every byte of a small four-sector array twice. This catches a design that overwrites a byte instead of clearing bits. It then erases one sector through an address whose upper bits are set, which catches an erase that leaks into a neighbouring sector or decodes the sector from the wrong bits. Broken unlock keys and wrong final erase codes are sent to catch a decoder that is too lenient. A full program sequence is sent while a chip erase runs, followed by a further data write after the erase ends; a decoder that kept stepping during `busy` would program a byte there. The busy window is counted cycle by cycle for each operation kind, which exposes off-by-one timer ends.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM,
        ST_ERS0,
        ST_ERS1,
        ST_ERS2,
        ST_AUTO,
        ST_BUSY_P,
        ST_BUSY_E
    } fc_state_e;

    typedef enum logic {
        RS_ARRAY,
        RS_CONST
    } rd_sel_e;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  OP_PROGRAM = 8'hA0;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  OP_IDENT   = 8'h90;
    localparam logic [7:0]  OP_RESET   = 8'hF0;
    localparam logic [7:0]  OP_SECTOR  = 8'h30;
    localparam logic [7:0]  OP_CHIP    = 8'h10;
    localparam logic [7:0]  ID_MAKER   = 8'h40;
    localparam logic [7:0]  ID_PART    = 8'h82;
    localparam logic [7:0]  STS_ERASE  = 8'h01;
    localparam logic [7:0]  STS_PROG   = 8'h02;
    localparam logic [7:0]  BYTE_BLANK = 8'hFF;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    import flash_cmd_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= BYTE_BLANK;
            end
            rdata_q <= BYTE_BLANK;
        end else if (en) begin
            if (we) begin
                mem_q[addr] <= wdata;
            end else begin
                rdata_q <= mem_q[addr];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm #(
    parameter int ADDR_W      = 18,
    parameter int ARRAY_AW    = 10,
    parameter int OFS_W       = 9,
    parameter int PROG_CYCLES = 6000,
    parameter int SECT_CYCLES = 2000000,
    parameter int CHIP_CYCLES = 600000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    input  logic [7:0]          arr_rdata,
    output logic                arr_en,
    output logic                arr_we,
    output logic [ARRAY_AW-1:0] arr_addr,
    output logic [7:0]          arr_wdata,
    output logic                busy,
    output logic                autosel,
    output logic                erasing
);
    import flash_cmd_pkg::*;

    localparam int DEPTH      = 1 << ARRAY_AW;
    localparam int SECT_BYTES = 1 << OFS_W;
    localparam int SECT_AW    = ARRAY_AW - OFS_W;
    localparam int PROG_N     = (PROG_CYCLES < 2) ? 2 : PROG_CYCLES;
    localparam int SECT_N     = (SECT_CYCLES < SECT_BYTES) ? SECT_BYTES : SECT_CYCLES;
    localparam int CHIP_N     = (CHIP_CYCLES < DEPTH) ? DEPTH : CHIP_CYCLES;
    localparam int MAX_A      = (PROG_N > SECT_N) ? PROG_N : SECT_N;
    localparam int MAX_N      = (MAX_A > CHIP_N) ? MAX_A : CHIP_N;
    localparam int TMR_W      = $clog2(MAX_N + 1);

    typedef struct packed {
        fc_state_e             state;
        logic [TMR_W-1:0]      tmr;
        logic [ARRAY_AW-1:0]   pa;
        logic [7:0]            pd;
        logic [SECT_AW-1:0]    esect;
        logic                  chip;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [14:0]      key_lo;
    logic             at_a;
    logic             key_a;
    logic             key_b;
    logic [TMR_W-1:0] er_span;
    logic [TMR_W-1:0] er_last;
    logic             unused_hi;

    assign key_lo    = addr[14:0];
    assign unused_hi = ^addr[ADDR_W-1:15];
    assign at_a      = (key_lo == KEY_ADDR_A);
    assign key_a     = at_a && (wdata == KEY_DATA_A);
    assign key_b     = (key_lo == KEY_ADDR_B) && (wdata == KEY_DATA_B);
    assign er_span   = seq_q.chip ? TMR_W'(DEPTH) : TMR_W'(SECT_BYTES);
    assign er_last   = seq_q.chip ? TMR_W'(CHIP_N - 1) : TMR_W'(SECT_N - 1);

    always_comb begin
        seq_d     = seq_q;
        arr_en    = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = addr[ARRAY_AW-1:0];
        arr_wdata = BYTE_BLANK;

        case (seq_q.state)
            ST_BUSY_P: begin
                seq_d.tmr = seq_q.tmr + 1'b1;
                if (seq_q.tmr == '0) begin
                    arr_en    = 1'b1;
                    arr_we    = 1'b1;
                    arr_addr  = seq_q.pa;
                    arr_wdata = seq_q.pd & arr_rdata;
                end
                if (seq_q.tmr == TMR_W'(PROG_N - 1)) begin
                    seq_d.state = ST_READ;
                    seq_d.tmr   = '0;
                end
            end
            ST_BUSY_E: begin
                seq_d.tmr = seq_q.tmr + 1'b1;
                if (seq_q.tmr < er_span) begin
                    arr_en = 1'b1;
                    arr_we = 1'b1;
                    if (seq_q.chip) begin
                        arr_addr = seq_q.tmr[ARRAY_AW-1:0];
                    end else begin
                        arr_addr = {seq_q.esect, seq_q.tmr[OFS_W-1:0]};
                    end
                end
                if (seq_q.tmr == er_last) begin
                    seq_d.state = ST_READ;
                    seq_d.tmr   = '0;
                end
            end
            default: begin
                if (wr_en) begin
                    seq_d.state = ST_READ;
                    case (seq_q.state)
                        ST_READ, ST_AUTO: begin
                            if (key_a) seq_d.state = ST_UNL1;
                        end
                        ST_UNL1: begin
                            if (key_b) seq_d.state = ST_UNL2;
                        end
                        ST_UNL2: begin
                            if (at_a && wdata == OP_PROGRAM) seq_d.state = ST_PGM;
                            else if (at_a && wdata == OP_ERASE) seq_d.state = ST_ERS0;
                            else if (at_a && wdata == OP_IDENT) seq_d.state = ST_AUTO;
                        end
                        ST_PGM: begin
                            arr_en      = 1'b1;
                            seq_d.pa    = addr[ARRAY_AW-1:0];
                            seq_d.pd    = wdata;
                            seq_d.tmr   = '0;
                            seq_d.state = ST_BUSY_P;
                        end
                        ST_ERS0: begin
                            if (key_a) seq_d.state = ST_ERS1;
                        end
                        ST_ERS1: begin
                            if (key_b) seq_d.state = ST_ERS2;
                        end
                        ST_ERS2: begin
                            if (wdata == OP_SECTOR) begin
                                seq_d.esect = addr[ARRAY_AW-1:OFS_W];
                                seq_d.chip  = 1'b0;
                                seq_d.tmr   = '0;
                                seq_d.state = ST_BUSY_E;
                            end else if (at_a && wdata == OP_CHIP) begin
                                seq_d.chip  = 1'b1;
                                seq_d.tmr   = '0;
                                seq_d.state = ST_BUSY_E;
                            end
                        end
                        default: seq_d.state = ST_READ;
                    endcase
                end else if (rd_en && seq_q.state != ST_AUTO) begin
                    arr_en = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_READ, tmr: '0, pa: '0, pd: '0, esect: '0, chip: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.state == ST_BUSY_P) || (seq_q.state == ST_BUSY_E);
    assign autosel = (seq_q.state == ST_AUTO);
    assign erasing = (seq_q.state == ST_BUSY_E);

    // R3
    prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_BUSY_P && arr_we) |-> ((arr_wdata & ~arr_rdata) == 8'h00));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && seq_q.tmr == '0) |=> (seq_q.state == $past(seq_q.state)));

endmodule

// File: rtl/flash_rd_ret.sv
module flash_rd_ret (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic       busy,
    input  logic       autosel,
    input  logic       erasing,
    input  logic [7:0] addr_lo,
    input  logic [7:0] arr_rdata,
    output logic [7:0] rdata
);
    import flash_cmd_pkg::*;

    typedef struct packed {
        rd_sel_e    sel;
        logic [7:0] cval;
    } ret_t;

    ret_t ret_d, ret_q;

    always_comb begin
        ret_d = ret_q;
        if (rd_en && !wr_en) begin
            if (busy) begin
                ret_d.sel  = RS_CONST;
                ret_d.cval = erasing ? STS_ERASE : STS_PROG;
            end else if (autosel) begin
                ret_d.sel = RS_CONST;
                case (addr_lo)
                    8'h00:   ret_d.cval = ID_MAKER;
                    8'h01:   ret_d.cval = ID_PART;
                    default: ret_d.cval = 8'h00;
                endcase
            end else begin
                ret_d.sel = RS_ARRAY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '{sel: RS_ARRAY, cval: 8'h00};
        end else begin
            ret_q <= ret_d;
        end
    end

    assign rdata = (ret_q.sel == RS_ARRAY) ? arr_rdata : ret_q.cval;

    // R11
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && busy) |=> (rdata == STS_ERASE || rdata == STS_PROG));

    // R6
    maker_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !busy && autosel && addr_lo == 8'h00) |=> (rdata == ID_MAKER));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W      = 18,
    parameter int ARRAY_AW    = 10,
    parameter int OFS_W       = 9,
    parameter int PROG_CYCLES = 6000,
    parameter int SECT_CYCLES = 2000000,
    parameter int CHIP_CYCLES = 600000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);
    localparam int DEPTH      = 1 << ARRAY_AW;
    localparam int SECT_BYTES = 1 << OFS_W;
    localparam int PROG_N     = (PROG_CYCLES < 2) ? 2 : PROG_CYCLES;
    localparam int SECT_N     = (SECT_CYCLES < SECT_BYTES) ? SECT_BYTES : SECT_CYCLES;
    localparam int CHIP_N     = (CHIP_CYCLES < DEPTH) ? DEPTH : CHIP_CYCLES;

    logic                arr_en;
    logic                arr_we;
    logic [ARRAY_AW-1:0] arr_addr;
    logic [7:0]          arr_wdata;
    logic [7:0]          arr_rdata;
    logic                autosel;
    logic                erasing;

    flash_seq_fsm #(
        .ADDR_W      (ADDR_W),
        .ARRAY_AW    (ARRAY_AW),
        .OFS_W       (OFS_W),
        .PROG_CYCLES (PROG_CYCLES),
        .SECT_CYCLES (SECT_CYCLES),
        .CHIP_CYCLES (CHIP_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .arr_rdata (arr_rdata),
        .arr_en    (arr_en),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .busy      (busy),
        .autosel   (autosel),
        .erasing   (erasing)
    );

    flash_array #(
        .AW (ARRAY_AW)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arr_en),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (arr_wdata),
        .rdata (arr_rdata)
    );

    flash_rd_ret u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .busy      (busy),
        .autosel   (autosel),
        .erasing   (erasing),
        .addr_lo   (addr[7:0]),
        .arr_rdata (arr_rdata),
        .rdata     (rdata)
    );

    logic [31:0] blen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen_q <= '0;
        end else begin
            blen_q <= busy ? blen_q + 1 : 32'd0;
        end
    end

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == 32'(PROG_N) || blen_q == 32'(SECT_N) || blen_q == 32'(CHIP_N)));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int AW    = 18;
    localparam int ARRW  = 8;
    localparam int OFSW  = 6;
    localparam int PROGN = 4;
    localparam int SECTN = 70;
    localparam int CHIPN = 260;
    localparam int DEPTH = 1 << ARRW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W      (AW),
        .ARRAY_AW    (ARRW),
        .OFS_W       (OFSW),
        .PROG_CYCLES (PROGN),
        .SECT_CYCLES (SECTN),
        .CHIP_CYCLES (CHIPN)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .busy  (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [AW-1:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic unlock();
        do_wr(18'h05555, 8'hAA);
        do_wr(18'h02AAA, 8'h55);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        int n;
        unlock();
        do_wr(18'h05555, 8'hA0);
        do_wr(a, d);
        wait_idle(n);
        exp_mem[a[ARRW-1:0]] &= d;
    endtask

    task automatic erase_pre();
        unlock();
        do_wr(18'h05555, 8'h80);
        unlock();
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            do_rd(AW'(i), v);
            chk(v == exp_mem[i], tag, v, exp_mem[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        sweep("R1 erased after reset");

        // R3 first pass, with program busy length (R9)
        unlock();
        do_wr(18'h05555, 8'hA0);
        do_wr(18'h00000, 8'h07);
        wait_idle(n);
        exp_mem[0] &= 8'h07;
        chk(n == PROGN, "R9 program busy length", n, PROGN);
        for (int i = 1; i < DEPTH; i++) prog(AW'(i), 8'((i * 29 + 7) & 8'hFF));
        sweep("R3 first program pass");

        // R3 second pass: bits only clear
        for (int i = 0; i < DEPTH; i++) prog(AW'(i), 8'((i * 113) ^ 8'hC3));
        sweep("R3 AND of two programs");

        // R11 status during program
        unlock();
        do_wr(18'h05555, 8'hA0);
        do_wr(18'h00005, 8'h0F);
        do_rd(18'h00005, v);
        chk(v == 8'h02, "R11 program status", v, 8'h02);
        wait_idle(n);
        exp_mem[5] &= 8'h0F;

        // R4 sector erase via address with high bits set, sector 2
        erase_pre();
        do_wr(18'h2AB95, 8'h30);
        wait_idle(n);
        chk(n == SECTN, "R9 sector erase busy length", n, SECTN);
        for (int i = 128; i < 192; i++) exp_mem[i] = 8'hFF;
        sweep("R4 only sector 2 erased");

        // R4/R8 wrong final erase code aborts
        erase_pre();
        do_wr(18'h00010, 8'h31);
        @(negedge clk);
        chk(busy == 1'b0, "R8 bad erase code no busy", busy, 0);
        do_rd(18'h00010, v);
        chk(v == exp_mem[16], "R8 bad erase code no change", v, exp_mem[16]);

        // R8 mismatched command step, then data write
        unlock();
        do_wr(18'h05555, 8'hFF);
        do_wr(18'h00020, 8'h00);
        do_rd(18'h00020, v);
        chk(v == exp_mem[32], "R8 FFh command aborts", v, exp_mem[32]);

        // R8 wrong second key address
        do_wr(18'h05555, 8'hAA);
        do_wr(18'h02AAB, 8'h55);
        do_wr(18'h05555, 8'hA0);
        do_wr(18'h00021, 8'h00);
        do_rd(18'h00021, v);
        chk(v == exp_mem[33], "R8 bad key address aborts", v, exp_mem[33]);

        // R2 upper address bits ignored on the key
        do_wr(18'h3D555, 8'hAA);
        do_wr(18'h2AAAA, 8'h55);
        do_wr(18'h1D555, 8'hA0);
        do_wr(18'h3FF90, 8'h00);
        wait_idle(n);
        exp_mem[8'h90] = 8'h00;
        do_rd(18'h00090, v);
        chk(v == 8'h00, "R2 key with high bits set", v, 8'h00);

        // R6 identification mode
        unlock();
        do_wr(18'h05555, 8'h90);
        do_rd(18'h00000, v);
        chk(v == 8'h40, "R6 maker code", v, 8'h40);
        do_rd(18'h00001, v);
        chk(v == 8'h82, "R6 part code", v, 8'h82);
        do_rd(18'h00002, v);
        chk(v == 8'h00, "R6 other id address", v, 8'h00);
        // R7 single F0h leaves
        do_wr(18'h00123, 8'hF0);
        do_rd(18'h00000, v);
        chk(v == exp_mem[0], "R7 single reset write", v, exp_mem[0]);

        // R7 reset after key
        unlock();
        do_wr(18'h05555, 8'h90);
        unlock();
        do_wr(18'h05555, 8'hF0);
        do_rd(18'h00001, v);
        chk(v == exp_mem[1], "R7 keyed reset", v, exp_mem[1]);

        // R5 chip erase with busy length
        erase_pre();
        do_wr(18'h05555, 8'h10);
        wait_idle(n);
        chk(n == CHIPN, "R9 chip erase busy length", n, CHIPN);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        sweep("R5 chip erased");

        prog(18'h00040, 8'h5A);
        sweep("R3 program after chip erase");

        // R10 writes during erase ignored, R11 erase status
        erase_pre();
        do_wr(18'h05555, 8'h10);
        do_rd(18'h00000, v);
        chk(v == 8'h01, "R11 erase status", v, 8'h01);
        unlock();
        do_wr(18'h05555, 8'hA0);
        do_wr(18'h00030, 8'h00);
        wait_idle(n);
        do_wr(18'h00031, 8'h00);
        @(negedge clk);
        chk(busy == 1'b0, "R10 decoder did not advance", busy, 0);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        sweep("R10 writes during erase ignored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule